// File: doc/BRIEF.md
# Indexed Postbyte Address Generator

This unit turns the indexed-addressing postbyte of a 16-bit accumulator-style CPU into an effective address. It takes the postbyte, up to two extension bytes that follow it, the address of the postbyte, and the current values of the pointer registers (X, Y, SP) and of the two 8-bit accumulators A and B. The 16-bit accumulator D is formed as A in the upper byte and B in the lower byte. One postbyte can select a short signed constant offset, a 9-bit or 16-bit constant offset, automatic pre/post increment or decrement of a pointer register, an accumulator offset, or one of two indirect forms.

For every accepted request the unit reports the effective address, the operand length in bytes, a flag saying that the address is a pointer still to be fetched, and, for the auto-modify forms, the register to update with its new value. When the instruction is a memory-to-memory move, the forms that need extension bytes are not allowed, and the unit flags them as invalid. Results go through one register stage. Memory access, the indirect fetch itself and instruction sequencing are left to the surrounding core.

Top module: `idx_addr_gen`

## Requirements
- R1: After reset, valid_out, eff_addr, wb_en, wb_sel, wb_val, op_len, indirect and invalid are all zero.
- R2: A postbyte with bit 5 = 0 selects a short constant offset. The base register is taken from bits 7:6 (0=X, 1=Y, 2=SP, 3=PC). Bits 4:0 are a two's-complement offset (-16..15). eff_addr = base + offset (mod 2^16) and op_len = 1.
- R3: A postbyte with bit 5 = 1 and bits 7:6 not equal to 3 selects auto-modify of the register in bits 7:6. If nibble bit 3 is 0, the step is +(nibble+1). If nibble bit 3 is 1, the step is the sign-extended nibble (-8..-1). wb_en = 1, wb_sel = register code, wb_val = register + step (mod 2^16), op_len = 1.
- R4: In auto-modify, bit 4 = 0 (pre-modify) gives eff_addr = wb_val. Bit 4 = 1 (post-modify) gives eff_addr = the unmodified register value.
- R5: A postbyte of the form 111rr00s adds a 9-bit signed offset formed as {s, first extension byte} to the register rr. op_len = 2.
- R6: A postbyte of the form 111rr010 adds the 16-bit offset {first extension byte, second extension byte} to the register rr. op_len = 3 and indirect = 0.
- R7: A postbyte of the form 111rr011 computes the same sum as R6 but sets indirect = 1. op_len = 3.
- R8: Postbytes of the form 111rr1cc add an accumulator to the register rr. cc=00 adds A zero-extended, cc=01 adds B zero-extended, cc=10 adds D. cc=11 adds D and sets indirect = 1. op_len = 1.
- R9: When the base register is PC, its value is post_addr + op_len, where post_addr is the address of the postbyte.
- R10: With is_move = 1, the forms of R5, R6 and R7 give invalid = 1, eff_addr = 0, op_len = 1, indirect = 0 and wb_en = 0. All other forms behave as they do with is_move = 0.
- R11: For every form other than auto-modify, wb_en = 0, wb_sel = 0 and wb_val = 0.
- R12: The outputs show the request sampled at a clock edge where valid_in = 1, and valid_out is high for the cycle that follows. While valid_in = 0, every result output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_in | input | 1 | Request present this cycle |
| is_move | input | 1 | Request belongs to a memory-to-memory move |
| postbyte | input | 8 | Indexed addressing postbyte |
| ext0 | input | 8 | First byte after the postbyte |
| ext1 | input | 8 | Second byte after the postbyte |
| post_addr | input | 16 | Address of the postbyte |
| reg_x | input | 16 | X register |
| reg_y | input | 16 | Y register |
| reg_sp | input | 16 | Stack pointer |
| acc_a | input | 8 | Accumulator A (high byte of D) |
| acc_b | input | 8 | Accumulator B (low byte of D) |
| valid_out | output | 1 | Result valid |
| eff_addr | output | 16 | Effective address or pointer address |
| wb_en | output | 1 | Register update required |
| wb_sel | output | 2 | Register to update (0=X, 1=Y, 2=SP) |
| wb_val | output | 16 | New register value |
| op_len | output | 2 | Bytes used by postbyte plus extensions |
| indirect | output | 1 | eff_addr is a pointer to fetch |
| invalid | output | 1 | Form not allowed in a move |

## Verification
On every cycle the assertions check the following. The invalid flag appears only for move requests. Indirect and invalid are never both set, and an update request never comes with an indirect result or a length above one. A pre-modify address equals the written-back value. A step never leaves the register unchanged. The result register follows valid_in with one cycle of latency and holds while idle. The actual arithmetic can only be shown by the bench scenarios, which compare against an independent model: the sign extension of the 5-bit, 9-bit and nibble offsets, the PC base that moves with the operand length, zero extension of A and B, and 16-bit wrap-around.

// File: rtl/idx_pkg.sv
package idx_pkg;
  localparam int BW   = 8;
  localparam int AW   = 2 * BW;
  localparam int LENW = 2;

  typedef enum logic [3:0] {
    MD_K5, MD_STEP, MD_K9, MD_K16, MD_K16_IND,
    MD_ACC_A, MD_ACC_B, MD_ACC_D, MD_D_IND
  } mode_e;

  typedef enum logic [1:0] {RS_X = 2'd0, RS_Y = 2'd1, RS_SP = 2'd2, RS_PC = 2'd3} rsel_e;

  typedef struct packed {
    logic [AW-1:0]   ea;
    logic            wb_en;
    logic [1:0]      wb_sel;
    logic [AW-1:0]   wb_val;
    logic [LENW-1:0] len;
    logic            ind;
    logic            inv;
  } res_t;

  function automatic logic [AW-1:0] sext5(input logic [4:0] v);
    return {{(AW-5){v[4]}}, v};
  endfunction

  function automatic logic [AW-1:0] step_of(input logic [3:0] nib);
    if (nib[3]) return {{(AW-4){1'b1}}, nib};
    return AW'(nib) + AW'(1);
  endfunction

  function automatic logic [AW-1:0] sext9(input logic s, input logic [BW-1:0] b);
    return {{(AW-BW){s}}, b};
  endfunction

  function automatic logic [AW-1:0] zext(input logic [BW-1:0] b);
    return {{(AW-BW){1'b0}}, b};
  endfunction

  function automatic logic [LENW-1:0] len_of(input mode_e m);
    case (m)
      MD_K9:              return LENW'(2);
      MD_K16, MD_K16_IND: return LENW'(3);
      default:            return LENW'(1);
    endcase
  endfunction
endpackage

// File: rtl/idx_decode.sv
module idx_decode
  import idx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_in,
  input  logic [7:0] postbyte,
  input  logic       is_move,
  output mode_e      mode,
  output rsel_e      rsel,
  output logic       is_post,
  output logic       bad_form,
  output logic       needs_ind
);
  always_comb begin
    is_post = postbyte[4];
    if (!postbyte[5]) begin
      mode = MD_K5;
      rsel = rsel_e'(postbyte[7:6]);
    end else if (postbyte[7:6] != 2'b11) begin
      mode = MD_STEP;
      rsel = rsel_e'(postbyte[7:6]);
    end else begin
      rsel = rsel_e'(postbyte[4:3]);
      if (postbyte[2:0] == 3'b011)  mode = MD_K16_IND;
      else if (!postbyte[2])        mode = postbyte[1] ? MD_K16 : MD_K9;
      else begin
        case (postbyte[1:0])
          2'b00:   mode = MD_ACC_A;
          2'b01:   mode = MD_ACC_B;
          2'b10:   mode = MD_ACC_D;
          default: mode = MD_D_IND;
        endcase
      end
    end
    bad_form  = is_move && (mode == MD_K9 || mode == MD_K16 || mode == MD_K16_IND);
    needs_ind = !bad_form && (mode == MD_K16_IND || mode == MD_D_IND);
  end

  // R10: an invalid flag never appears outside a move request
  a_r10_invalid_only_move: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && bad_form) |-> is_move);
  // R3: auto-modify never targets PC
  a_r3_step_not_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && mode == MD_STEP) |-> rsel != RS_PC);
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_in,
  input  mode_e               mode,
  input  rsel_e               rsel,
  input  logic                is_post,
  input  logic [7:0]          postbyte,
  input  logic [BW-1:0]       ext0,
  input  logic [BW-1:0]       ext1,
  input  logic [AW-1:0]       post_addr,
  input  logic [AW-1:0]       reg_x,
  input  logic [AW-1:0]       reg_y,
  input  logic [AW-1:0]       reg_sp,
  input  logic [BW-1:0]       acc_a,
  input  logic [BW-1:0]       acc_b,
  output logic [AW-1:0]       ea,
  output logic                wb_en,
  output logic [AW-1:0]       wb_val,
  output logic [LENW-1:0]     len
);
  logic [AW-1:0] base;
  logic [AW-1:0] off;
  logic [AW-1:0] sum;

  always_comb begin
    len = len_of(mode);
    case (rsel)
      RS_X:    base = reg_x;
      RS_Y:    base = reg_y;
      RS_SP:   base = reg_sp;
      default: base = post_addr + AW'(len);
    endcase
    wb_en = 1'b0;
    case (mode)
      MD_K5:                off = sext5(postbyte[4:0]);
      MD_STEP: begin        off = step_of(postbyte[3:0]); wb_en = 1'b1; end
      MD_K9:                off = sext9(postbyte[0], ext0);
      MD_K16, MD_K16_IND:   off = {ext0, ext1};
      MD_ACC_A:             off = zext(acc_a);
      MD_ACC_B:             off = zext(acc_b);
      default:              off = {acc_a, acc_b};
    endcase
    sum    = base + off;
    wb_val = wb_en ? sum : '0;
    ea     = (wb_en && is_post) ? base : sum;
  end

  // R4: pre-modify address equals the value written back
  a_r4_pre_matches_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && wb_en && !is_post) |-> ea == wb_val);
  // R3: a step always changes the register
  a_r3_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && wb_en) |-> wb_val != base);
endmodule

// File: rtl/idx_out_reg.sv
module idx_out_reg
  import idx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic valid_in,
  input  res_t d,
  output logic valid_q,
  output res_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      q       <= '0;
    end else begin
      valid_q <= valid_in;
      if (valid_in) q <= d;
    end
  end

  // R12: one cycle latency
  a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_q);
  // R12: results hold while idle
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(q));
  // R10: indirect and invalid exclusive
  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> !(q.inv && q.ind));
  // R11: an update comes only with a one-byte, direct, valid result
  a_r11_wb_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && q.wb_en) |-> (q.len == LENW'(1) && !q.ind && !q.inv));
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen
  import idx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_in,
  input  logic          is_move,
  input  logic [7:0]    postbyte,
  input  logic [7:0]    ext0,
  input  logic [7:0]    ext1,
  input  logic [15:0]   post_addr,
  input  logic [15:0]   reg_x,
  input  logic [15:0]   reg_y,
  input  logic [15:0]   reg_sp,
  input  logic [7:0]    acc_a,
  input  logic [7:0]    acc_b,
  output logic          valid_out,
  output logic [15:0]   eff_addr,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [15:0]   wb_val,
  output logic [1:0]    op_len,
  output logic          indirect,
  output logic          invalid
);
  mode_e           mode;
  rsel_e           rsel;
  logic            is_post, bad_form, needs_ind;
  logic [AW-1:0]   c_ea, c_wb;
  logic            c_wb_en;
  logic [LENW-1:0] c_len;
  res_t            res_d, res_q;

  idx_decode u_dec (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .postbyte(postbyte),
    .is_move(is_move), .mode(mode), .rsel(rsel), .is_post(is_post),
    .bad_form(bad_form), .needs_ind(needs_ind)
  );

  idx_ea_calc u_calc (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .mode(mode), .rsel(rsel),
    .is_post(is_post), .postbyte(postbyte), .ext0(ext0), .ext1(ext1),
    .post_addr(post_addr), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp),
    .acc_a(acc_a), .acc_b(acc_b), .ea(c_ea), .wb_en(c_wb_en), .wb_val(c_wb),
    .len(c_len)
  );

  always_comb begin
    res_d.inv    = bad_form;
    res_d.ind    = needs_ind;
    res_d.ea     = bad_form ? '0 : c_ea;
    res_d.len    = bad_form ? LENW'(1) : c_len;
    res_d.wb_en  = c_wb_en;
    res_d.wb_sel = c_wb_en ? rsel : 2'd0;
    res_d.wb_val = c_wb;
  end

  idx_out_reg u_oreg (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .d(res_d),
    .valid_q(valid_out), .q(res_q)
  );

  assign eff_addr = res_q.ea;
  assign wb_en    = res_q.wb_en;
  assign wb_sel   = res_q.wb_sel;
  assign wb_val   = res_q.wb_val;
  assign op_len   = res_q.len;
  assign indirect = res_q.ind;
  assign invalid  = res_q.inv;
endmodule

// File: tb/test_idx_addr_gen.sv
module test_idx_addr_gen;
  logic clk = 0, rst_n = 0, valid_in = 0, is_move = 0;
  logic [7:0] postbyte = 0, ext0 = 0, ext1 = 0, acc_a = 0, acc_b = 0;
  logic [15:0] post_addr = 0, reg_x = 0, reg_y = 0, reg_sp = 0;
  logic valid_out, wb_en, indirect, invalid;
  logic [15:0] eff_addr, wb_val;
  logic [1:0] wb_sel, op_len;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  idx_addr_gen i_idx_addr_gen (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  int e_ea, e_wen, e_sel, e_wv, e_len, e_ind, e_inv;
  string e_tag;

  task automatic model();
    int base, off, len, r, n;
    bit auto_m;
    auto_m = 0; e_ind = 0; e_inv = 0;
    if (postbyte[5] == 0) begin
      r = postbyte[7:6]; len = 1;
      off = postbyte[4] ? int'(postbyte[4:0]) - 32 : int'(postbyte[4:0]); e_tag = "R2";
    end else if (postbyte[7:6] != 3) begin
      r = postbyte[7:6]; len = 1; auto_m = 1; n = postbyte[3:0];
      off = (n < 8) ? n + 1 : n - 16; e_tag = "R3_R4";
    end else begin
      r = postbyte[4:3];
      if (postbyte[2:0] == 3) begin len = 3; off = {ext0, ext1}; e_ind = 1; e_tag = "R7"; end
      else if (postbyte[2] == 0 && postbyte[1]) begin len = 3; off = {ext0, ext1}; e_tag = "R6"; end
      else if (postbyte[2] == 0) begin len = 2; off = postbyte[0] ? int'(ext0) - 256 : int'(ext0); e_tag = "R5"; end
      else begin
        len = 1; e_tag = "R8";
        case (postbyte[1:0])
          0: off = acc_a;
          1: off = acc_b;
          default: off = {acc_a, acc_b};
        endcase
        e_ind = (postbyte[1:0] == 3);
      end
    end
    case (r)
      0: base = reg_x;
      1: base = reg_y;
      2: base = reg_sp;
      default: begin base = post_addr + len; e_tag = {e_tag, "_R9"}; end
    endcase
    e_ea = (base + off) & 16'hFFFF;
    e_len = len; e_wen = 0; e_sel = 0; e_wv = 0;
    if (auto_m) begin
      e_wen = 1; e_sel = r; e_wv = e_ea;
      if (postbyte[4]) e_ea = base;
    end
    if (is_move && len > 1) begin
      e_inv = 1; e_ea = 0; e_len = 1; e_ind = 0; e_tag = {e_tag, "_R10"};
    end
  endtask

  task automatic run_one(input bit idle_after);
    logic [15:0] h_ea, h_wv;
    model();
    valid_in = 1;
    @(posedge clk); @(negedge clk);
    chk({e_tag, " R12 valid"}, valid_out, 1);
    chk({e_tag, " ea"}, eff_addr, e_ea);
    chk({e_tag, " len"}, op_len, e_len);
    chk({e_tag, " ind"}, indirect, e_ind);
    chk({e_tag, " inv"}, invalid, e_inv);
    chk({e_tag, " R11 wb_en"}, wb_en, e_wen);
    chk({e_tag, " R11 wb_sel"}, wb_sel, e_sel);
    chk({e_tag, " R11 wb_val"}, wb_val, e_wv);
    valid_in = 0;
    if (idle_after) begin
      h_ea = eff_addr; h_wv = wb_val;
      postbyte = 8'($urandom); reg_x = 16'($urandom); reg_y = 16'($urandom);
      reg_sp = 16'($urandom); acc_a = 8'($urandom); acc_b = 8'($urandom);
      @(posedge clk); @(negedge clk);
      chk("R12 idle valid", valid_out, 0);
      chk("R12 hold ea", eff_addr, h_ea);
      chk("R12 hold wb_val", wb_val, h_wv);
    end
  endtask

  task automatic set(input logic [7:0] pb, input logic mv, input logic [7:0] a0, input logic [7:0] a1);
    postbyte = pb; is_move = mv; ext0 = a0; ext1 = a1;
  endtask

  initial begin
    void'($urandom(32'h1D5A7));
    #1;
    chk("R1 valid", valid_out, 0); chk("R1 ea", eff_addr, 0);
    chk("R1 wb_en", wb_en, 0); chk("R1 len", op_len, 0);
    chk("R1 ind", indirect, 0); chk("R1 inv", invalid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    reg_x = 16'h1000; reg_y = 16'hFFFE; reg_sp = 16'h0004; post_addr = 16'h8000;
    acc_a = 8'hFF; acc_b = 8'h80;
    set(8'h10, 0, 0, 0); run_one(1);          // R2 X-16
    set(8'hCF, 0, 0, 0); run_one(0);          // R2 PC+15
    set(8'h67, 0, 0, 0); run_one(0);          // R3 pre +8 on Y, wraps
    set(8'hB8, 0, 0, 0); run_one(1);          // R4 post -8 on SP
    set(8'h2F, 0, 0, 0); run_one(0);          // R4 pre -1 on X
    set(8'hE1, 0, 8'h01, 0); run_one(0);      // R5 -255 on X
    set(8'hFA, 0, 8'h12, 8'h34); run_one(0);  // R6 PC 16-bit
    set(8'hEB, 0, 8'hF0, 8'h00); run_one(0);  // R7 Y indirect
    set(8'hE4, 0, 0, 0); run_one(0);          // R8 A zero-ext
    set(8'hED, 0, 0, 0); run_one(0);          // R8 B zero-ext
    set(8'hF6, 0, 0, 0); run_one(0);          // R8 D on SP
    set(8'hE7, 0, 0, 0); run_one(0);          // R8 D indirect
    set(8'hE0, 1, 8'h05, 0); run_one(0);      // R10 9-bit in move
    set(8'hE2, 1, 8'h05, 0); run_one(0);      // R10 16-bit in move
    set(8'hE3, 1, 8'h05, 0); run_one(1);      // R10 indirect in move
    set(8'hE4, 1, 0, 0); run_one(0);          // R10 allowed form in move
    set(8'h08, 1, 0, 0); run_one(0);          // R10 short form in move
    for (int k = 0; k < 600; k++) begin
      postbyte = 8'($urandom); ext0 = 8'($urandom); ext1 = 8'($urandom);
      is_move = ($urandom % 4) == 0; post_addr = 16'($urandom);
      reg_x = 16'($urandom); reg_y = 16'($urandom); reg_sp = 16'($urandom);
      acc_a = 8'($urandom); acc_b = 8'($urandom);
      run_one(($urandom % 5) == 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R12 actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule